// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from sixteen maskable sources and two non-maskable sources (an external pin and a watchdog). It decides which request the CPU should service next. Every maskable source has a request flag, a mask bit, a two-bit programmed priority and a two-bit service-mode field. A request pulse sets the flag, and the flag stays set until the CPU acknowledges that source. Arbitration has two tiers. The programmed priority decides first, and among equal priorities the lower source number wins. Two source slots accept a second trigger (a compare-match event) that is ORed into the same flag.

The winner is captured in output registers together with its vector address, its source number and its service mode (vectored, macro service or context switch). The CPU sees a registered request line. The captured result stays frozen until the CPU pulses the acknowledge input. The CPU reports the level it is currently servicing. A maskable request is forwarded only when its priority is strictly more urgent than that level, which allows nesting. The fixed vectors for the break instruction, the illegal-opcode trap and reset are provided as constant outputs.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `irq` is 0. After reset no request flag is set.
- R2: A one-cycle pulse on a request input sets that source's flag. The flag stays set until the CPU acknowledges that source. Several pulses before the acknowledge produce exactly one service.
- R3: Priority value 0 is the most urgent of the four levels and value 3 the least. Among eligible requests, the one with the most urgent programmed priority is selected.
- R4: Among eligible requests with equal programmed priority, the lower source number is selected.
- R5: For maskable source n, `vec_addr` is 0x0006 + 2·n and `src_id` is n. `svc_mode` equals the source's mode field, where 0 is vectored, 1 is macro service and 2 is context switch. A field value of 3 is reported as 0.
- R6: While a source's mask bit is 1, that source is not selected but its flag stays set. Once the mask bit is cleared, the source is serviced.
- R7: A maskable request is eligible only if its priority value is numerically less than `svc_level`. The value 4 means nothing is in service, and a value of 0 blocks every maskable source.
- R8: The pin request (`src_id` 16, vector 0x0002) wins over the watchdog request (`src_id` 17, vector 0x0004). Both win over all maskable requests, whatever the mask and the level. Both report mode 0.
- R9: Sources 1 and 4 also accept `alt_pulse`. `alt_pulse` on any other source has no effect.
- R10: While `irq` is 1 and `ack` is 0, `vec_addr`, `src_id` and `svc_mode` hold their values even if more urgent requests arrive. An acknowledge drops `irq` in the next cycle.
- R11: `brk_vec` is 0x003E, `trap_vec` is 0x003C and `rst_vec` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_pulse | input | 16 | Per-source primary request pulses |
| alt_pulse | input | 16 | Second trigger, honoured on shared slots only |
| nmi_pulse | input | 1 | Non-maskable pin request pulse |
| wdt_pulse | input | 1 | Watchdog request pulse |
| mask | input | 16 | Per-source mask, 1 = blocked |
| prio | input | 32 | Two bits per source, source n at [2n+1:2n] |
| mode_sel | input | 32 | Two bits per source, source n at [2n+1:2n] |
| svc_level | input | 3 | Current in-service level, 4 = none |
| ack | input | 1 | CPU acknowledge of the presented request |
| irq | output | 1 | Registered interrupt request to the CPU |
| vec_addr | output | 16 | Vector address of the presented request |
| src_id | output | 5 | Source number (16 = pin, 17 = watchdog) |
| svc_mode | output | 2 | Service mode of the presented request |
| brk_vec | output | 16 | Break-instruction vector |
| trap_vec | output | 16 | Illegal-opcode trap vector |
| rst_vec | output | 16 | Reset vector |

## Verification
The bench builds the block with the default parameters: sixteen sources, two-bit priorities, and the shared-slot mask selecting sources 1 and 4. This brings the whole maskable vector span from 0x0006 to 0x0024 within reach, along with all four priority values, the "nothing in service" level and both dual-trigger slots. The stimulus fires groups of simultaneous requests to exercise both tiers of arbitration. It holds blocked requests behind masks and levels and then releases them. It also injects non-maskable requests while a maskable one is waiting for acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        MODE_VECT  = 2'd0,
        MODE_MACRO = 2'd1,
        MODE_CTXSW = 2'd2
    } svc_mode_e;

    localparam logic [15:0] BRK_VEC_C  = 16'h003E;
    localparam logic [15:0] TRAP_VEC_C = 16'h003C;
    localparam logic [15:0] RST_VEC_C  = 16'h0000;

    // reserved field value is folded onto plain vectored handling
    function automatic svc_mode_e decode_mode(input logic [1:0] f);
        case (f)
            2'd1:    return MODE_MACRO;
            2'd2:    return MODE_CTXSW;
            default: return MODE_VECT;
        endcase
    endfunction

endpackage

// File: rtl/intc_req_flags.sv
module intc_req_flags #(
    parameter int               N_SRC  = 16,
    parameter logic [N_SRC-1:0] SHARED = 16'h0012
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_pulse,
    input  logic [N_SRC-1:0] alt_pulse,
    input  logic             nmi_pulse,
    input  logic             wdt_pulse,
    input  logic [N_SRC-1:0] clr_msk,
    input  logic             clr_nmi,
    input  logic             clr_wdt,
    output logic [N_SRC-1:0] pend,
    output logic             nmi_pend,
    output logic             wdt_pend
);

    typedef struct packed {
        logic [N_SRC-1:0] msk;
        logic             nmi;
        logic             wdt;
    } flag_t;

    flag_t            flg_d, flg_q;
    logic [N_SRC-1:0] set_vec;
    logic             unused_alt;

    for (genvar g = 0; g < N_SRC; g++) begin : g_trig
        if (SHARED[g]) begin : g_dual
            assign set_vec[g] = req_pulse[g] | alt_pulse[g];
        end else begin : g_single
            assign set_vec[g] = req_pulse[g];
        end
    end

    assign unused_alt = ^(alt_pulse & ~SHARED);

    always_comb begin
        flg_d     = flg_q;
        flg_d.msk = (flg_q.msk & ~clr_msk) | set_vec;
        flg_d.nmi = (flg_q.nmi & ~clr_nmi) | nmi_pulse;
        flg_d.wdt = (flg_q.wdt & ~clr_wdt) | wdt_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign pend     = flg_q.msk;
    assign nmi_pend = flg_q.nmi;
    assign wdt_pend = flg_q.wdt;

endmodule

// File: rtl/intc_select.sv
module intc_select #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 2,
    parameter int ID_W   = 5,
    parameter int LVL_W  = PRIO_W + 1
) (
    input  logic [N_SRC-1:0]        pend,
    input  logic [N_SRC-1:0]        mask,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    input  logic [LVL_W-1:0]        svc_level,
    input  logic                    nmi_pend,
    input  logic                    wdt_pend,
    output logic                    hit,
    output logic [ID_W-1:0]         win_id
);

    logic              best_ok;
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_i;
    logic [PRIO_W-1:0] cur_p;

    always_comb begin
        best_ok = 1'b0;
        best_p  = '0;
        best_i  = '0;
        cur_p   = '0;
        // ascending scan with strict compare: the lower index keeps a tie
        for (int i = 0; i < N_SRC; i++) begin
            cur_p = prio[i*PRIO_W +: PRIO_W];
            if (pend[i] && !mask[i] && ({1'b0, cur_p} < svc_level)
                && (!best_ok || cur_p < best_p)) begin
                best_ok = 1'b1;
                best_p  = cur_p;
                best_i  = ID_W'(i);
            end
        end
        if (nmi_pend) begin
            hit    = 1'b1;
            win_id = ID_W'(N_SRC);
        end else if (wdt_pend) begin
            hit    = 1'b1;
            win_id = ID_W'(N_SRC + 1);
        end else begin
            hit    = best_ok;
            win_id = best_i;
        end
    end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int               N_SRC    = 16,
    parameter int               PRIO_W   = 2,
    parameter int               VEC_W    = 16,
    parameter int               VEC_STEP = 2,
    parameter logic [VEC_W-1:0] MSK_BASE = 16'h0006,
    parameter logic [VEC_W-1:0] NMI_VEC  = 16'h0002,
    parameter logic [VEC_W-1:0] WDT_VEC  = 16'h0004,
    parameter logic [N_SRC-1:0] SHARED   = 16'h0012,
    localparam int              ID_W     = $clog2(N_SRC + 2),
    localparam int              LVL_W    = PRIO_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req_pulse,
    input  logic [N_SRC-1:0]        alt_pulse,
    input  logic                    nmi_pulse,
    input  logic                    wdt_pulse,
    input  logic [N_SRC-1:0]        mask,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    input  logic [N_SRC*2-1:0]      mode_sel,
    input  logic [LVL_W-1:0]        svc_level,
    input  logic                    ack,
    output logic                    irq,
    output logic [VEC_W-1:0]        vec_addr,
    output logic [ID_W-1:0]         src_id,
    output logic [1:0]              svc_mode,
    output logic [VEC_W-1:0]        brk_vec,
    output logic [VEC_W-1:0]        trap_vec,
    output logic [VEC_W-1:0]        rst_vec
);

    localparam logic [ID_W-1:0] ID_NMI = ID_W'(N_SRC);
    localparam logic [ID_W-1:0] ID_WDT = ID_W'(N_SRC + 1);

    typedef struct packed {
        logic             irq;
        logic [ID_W-1:0]  id;
        logic [VEC_W-1:0] vec;
        logic [1:0]       mode;
    } pres_t;

    pres_t            st_d, st_q;
    logic [N_SRC-1:0] pend, clr_msk;
    logic             nmi_pend, wdt_pend, clr_nmi, clr_wdt;
    logic             hit, take_ack;
    logic [ID_W-1:0]  win_id;

    intc_req_flags #(.N_SRC(N_SRC), .SHARED(SHARED)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pulse (req_pulse),
        .alt_pulse (alt_pulse),
        .nmi_pulse (nmi_pulse),
        .wdt_pulse (wdt_pulse),
        .clr_msk   (clr_msk),
        .clr_nmi   (clr_nmi),
        .clr_wdt   (clr_wdt),
        .pend      (pend),
        .nmi_pend  (nmi_pend),
        .wdt_pend  (wdt_pend)
    );

    intc_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .LVL_W(LVL_W)) i_select (
        .pend      (pend),
        .mask      (mask),
        .prio      (prio),
        .svc_level (svc_level),
        .nmi_pend  (nmi_pend),
        .wdt_pend  (wdt_pend),
        .hit       (hit),
        .win_id    (win_id)
    );

    assign take_ack = st_q.irq && ack;

    always_comb begin
        st_d    = st_q;
        clr_msk = '0;
        clr_nmi = take_ack && (st_q.id == ID_NMI);
        clr_wdt = take_ack && (st_q.id == ID_WDT);
        if (take_ack && st_q.id < ID_NMI) begin
            clr_msk = N_SRC'(1) << st_q.id;
        end
        if (st_q.irq) begin
            if (ack) st_d.irq = 1'b0;
        end else if (hit) begin
            st_d.irq = 1'b1;
            st_d.id  = win_id;
            if (win_id == ID_NMI) begin
                st_d.vec  = NMI_VEC;
                st_d.mode = MODE_VECT;
            end else if (win_id == ID_WDT) begin
                st_d.vec  = WDT_VEC;
                st_d.mode = MODE_VECT;
            end else begin
                st_d.vec  = MSK_BASE + VEC_W'(VEC_STEP) * VEC_W'(win_id);
                st_d.mode = decode_mode(mode_sel[32'(win_id)*2 +: 2]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq      = st_q.irq;
    assign vec_addr = st_q.vec;
    assign src_id   = st_q.id;
    assign svc_mode = st_q.mode;
    assign brk_vec  = VEC_W'(BRK_VEC_C);
    assign trap_vec = VEC_W'(TRAP_VEC_C);
    assign rst_vec  = VEC_W'(RST_VEC_C);

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int N_SRC = 16,
    parameter int VEC_W = 16,
    parameter int ID_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             ack,
    input logic [VEC_W-1:0] vec_addr,
    input logic [ID_W-1:0]  src_id,
    input logic [1:0]       svc_mode
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack |=> irq && $stable(vec_addr) && $stable(src_id) && $stable(svc_mode));

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && ack |=> !irq);

    // R8
    nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && src_id == ID_W'(N_SRC) |-> vec_addr == VEC_W'(2) && svc_mode == 2'd0);

    // R8
    wdt_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && src_id == ID_W'(N_SRC + 1) |-> vec_addr == VEC_W'(4) && svc_mode == 2'd0);

    // R5
    msk_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && src_id < ID_W'(N_SRC) |-> vec_addr == VEC_W'(6) + VEC_W'(2) * VEC_W'(src_id)
                                        && svc_mode != 2'd3);

endmodule

bind prio_vec_intc intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .ID_W(ID_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .ack      (ack),
    .vec_addr (vec_addr),
    .src_id   (src_id),
    .svc_mode (svc_mode)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;

    typedef struct {
        int    id;
        int    vec;
        int    mode;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_pulse = '0;
    logic [15:0] alt_pulse = '0;
    logic        nmi_pulse = 1'b0;
    logic        wdt_pulse = 1'b0;
    logic [15:0] mask = '0;
    logic [31:0] prio;
    logic [31:0] mode_sel;
    logic [2:0]  svc_level = 3'd4;
    logic        ack = 1'b0;
    logic        irq;
    logic [15:0] vec_addr;
    logic [4:0]  src_id;
    logic [1:0]  svc_mode;
    logic [15:0] brk_vec, trap_vec, rst_vec;

    logic [1:0] prio_cfg [16];
    logic [1:0] mode_cfg [16];

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   hold   = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            prio[i*2 +: 2]     = prio_cfg[i];
            mode_sel[i*2 +: 2] = mode_cfg[i];
        end
    end

    prio_vec_intc i_prio_vec_intc (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .alt_pulse(alt_pulse),
        .nmi_pulse(nmi_pulse), .wdt_pulse(wdt_pulse), .mask(mask), .prio(prio),
        .mode_sel(mode_sel), .svc_level(svc_level), .ack(ack), .irq(irq),
        .vec_addr(vec_addr), .src_id(src_id), .svc_mode(svc_mode),
        .brk_vec(brk_vec), .trap_vec(trap_vec), .rst_vec(rst_vec)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver side: expected item from the requirements
    task automatic expect_src(input int id, input string tag);
        exp_t e;
        e.id  = id;
        e.tag = tag;
        if (id == 16)      begin e.vec = 'h2; e.mode = 0; end
        else if (id == 17) begin e.vec = 'h4; e.mode = 0; end
        else begin
            e.vec  = 'h6 + 2 * id;
            e.mode = (mode_cfg[id] == 2'd3) ? 0 : int'(mode_cfg[id]);
        end
        q.push_back(e);
    endtask

    task automatic fire(input logic [15:0] r, input logic [15:0] a, input bit n, input bit w);
        @(negedge clk);
        req_pulse = r; alt_pulse = a; nmi_pulse = n; wdt_pulse = w;
        @(negedge clk);
        req_pulse = '0; alt_pulse = '0; nmi_pulse = 1'b0; wdt_pulse = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(irq == 1'b0, tag, irq, 0);
        end
    endtask

    // monitor: compare presented request against queue head, ack after 3 cycles
    always @(negedge clk) begin
        ack = 1'b0;
        if (rst_n && irq) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected request", src_id, 'hFF);
                ack = 1'b1;
            end else begin
                check(src_id == q[0].id,        {q[0].tag, " id"},   src_id,   q[0].id);
                check(vec_addr == q[0].vec,     {q[0].tag, " vec"},  vec_addr, q[0].vec);
                check(svc_mode == q[0].mode,    {q[0].tag, " mode"}, svc_mode, q[0].mode);
                hold++;
                if (hold == 3) begin
                    ack  = 1'b1;
                    hold = 0;
                    void'(q.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin prio_cfg[i] = 2'd3; mode_cfg[i] = 2'd0; end
        repeat (4) @(negedge clk);
        check(irq == 1'b0, "R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        expect_idle(5, "R1 idle after reset");
        check(brk_vec == 16'h003E,  "R11 brk", brk_vec, 'h3E);
        check(trap_vec == 16'h003C, "R11 trap", trap_vec, 'h3C);
        check(rst_vec == 16'h0000,  "R11 reset", rst_vec, 0);

        // R3 R5: two-tier order and modes
        prio_cfg[12] = 2'd0; prio_cfg[3] = 2'd1; prio_cfg[9] = 2'd1; prio_cfg[0] = 2'd2;
        mode_cfg[12] = 2'd2; mode_cfg[3] = 2'd1; mode_cfg[15] = 2'd3;
        expect_src(12, "R3 p0"); expect_src(3, "R4 p1 low"); expect_src(9, "R4 p1 high");
        expect_src(0, "R3 p2");  expect_src(15, "R5 reserved mode");
        fire(16'h9209, '0, 0, 0);
        drain();

        // R4: equal priority
        expect_src(2, "R4 tie a"); expect_src(7, "R4 tie b"); expect_src(14, "R4 tie c");
        fire(16'h4084, '0, 0, 0);
        drain();

        // R8: non-maskable order, then regardless of mask and level
        expect_src(16, "R8 pin"); expect_src(17, "R8 wdt"); expect_src(5, "R8 maskable last");
        prio_cfg[5] = 2'd0;
        fire(16'h0020, '0, 1, 1);
        drain();
        mask = 16'hFFFF; svc_level = 3'd0;
        expect_src(17, "R8 wdt masked all");
        fire(16'h0001, '0, 0, 1);
        drain();
        expect_idle(6, "R7 level 0 blocks");
        mask = '0; svc_level = 3'd4;
        expect_src(0, "R7 release level");
        drain();

        // R6: mask holds the flag
        mask[6] = 1'b1;
        fire(16'h0040, '0, 0, 0);
        expect_idle(10, "R6 masked quiet");
        expect_src(6, "R6 unmasked serve");
        mask[6] = 1'b0;
        drain();

        // R7: level gating
        prio_cfg[8] = 2'd1; prio_cfg[11] = 2'd2; svc_level = 3'd2;
        expect_src(8, "R7 above level");
        fire(16'h0900, '0, 0, 0);
        drain();
        expect_idle(10, "R7 gated quiet");
        expect_src(11, "R7 level raised");
        svc_level = 3'd3;
        drain();
        svc_level = 3'd4;

        // R9: shared slots
        expect_src(1, "R9 alt slot1"); expect_src(4, "R9 alt slot4");
        fire('0, 16'h0012, 0, 0);
        drain();
        fire('0, 16'hFFED, 0, 0);
        expect_idle(10, "R9 alt ignored");

        // R2: repeated pulses give one service
        expect_src(13, "R2 single service");
        fire(16'h2000, '0, 0, 0);
        fire(16'h2000, '0, 0, 0);
        drain();
        expect_idle(10, "R2 flag cleared");

        // R10: hold while a more urgent request arrives
        expect_src(10, "R10 held"); expect_src(16, "R10 pin after ack");
        fire(16'h0400, '0, 0, 0);
        while (!irq) @(negedge clk);
        fire('0, '0, 1, 0);
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule